// File: doc/BRIEF.md
# Clock Output Pin Selector

This block drives one output pad that serves either as a general-purpose output or as a clock output. A two-bit select field, held in the low bits of an 8-bit clock control register, chooses the pad's source. The source is the GPIO data bit, the oscillator clock itself, the oscillator divided by two, or the oscillator divided by four. Both divided clocks come from one free-running two-bit counter on the oscillator, so each has a 50% duty cycle.

Software may rewrite the select field at any moment while the oscillator runs. The register takes the new value at once, but the pad changes source only on a falling oscillator edge. At that edge the current source and the requested source must both sit low for the low phase that follows. As a result, the pad never shows a high or low interval shorter than half an oscillator period. If the current source stays high, for example a GPIO bit held at one, the change waits until it drops.

Top module: `clkout_pin_mux`

## Requirements
- R1: While `rst_n` is low and after its release, the select field is 00 and `pad_out` follows `gpio_dout`.
- R2: A rising `clk_osc` edge with `ctrl_wr` high loads `ctrl_wdata[1:0]` as the select field. `ctrl_wdata[7:2]` have no effect. Without a write the select field holds.
- R3: With select 00 in effect, `pad_out` equals `gpio_dout`.
- R4: With select 01 in effect, `pad_out` follows `clk_osc`: one oscillator period per cycle, high for half of it.
- R5: With select 10 in effect, `pad_out` has a period of 2 oscillator cycles and is high for 1 cycle.
- R6: With select 11 in effect, `pad_out` has a period of 4 oscillator cycles and is high for 2 cycles.
- R7: A new select value takes effect at the first falling `clk_osc` edge at which both the current and the requested source are low for the coming low phase. Example: with GPIO low, writing 01 on rising edge P makes the switch at the following falling edge, and `pad_out` is high just after rising edge P+1.
- R8: Across any sequence of select rewrites, with `gpio_dout` changing only in whole oscillator cycles, no high or low interval on `pad_out` is shorter than half an oscillator period.
- R9: While the current source stays high, the requested mode is not taken up and `pad_out` stays high. It switches once that source goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock; also the undivided clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the clock control register |
| ctrl_wdata | input | 8 | Write data; bits [1:0] are the select field |
| gpio_dout | input | 1 | GPIO output value used in mode 00 |
| pad_out | output | 1 | Shared pad output |

## Verification
Directed writes put each mode in force, and the period and high time are then measured on the pad. This separates the three clock ratios from one another and from GPIO passthrough. Writes that carry junk in the upper bits show whether only the low two bits decode. A GPIO bit held high during a request for a clock mode separates a handoff that waits for a low level from one that switches at once. Random rewrites of the select field, mixed with random GPIO levels, are watched by a pulse-width monitor that catches any runt caused by switching at the wrong phase.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int CTRL_W  = 8;
  localparam int SEL_LSB = 0;
  localparam int SEL_W   = 2;
  localparam int DIV_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    PIN_GPIO    = 2'b00,
    PIN_OSC     = 2'b01,
    PIN_HALF    = 2'b10,
    PIN_QUARTER = 2'b11
  } pin_mode_e;

  // Level a source holds through the oscillator low phase that follows a falling edge.
  function automatic logic low_phase_level(pin_mode_e m, logic [DIV_W-1:0] cnt, logic gpio);
    logic lvl;
    unique case (m)
      PIN_GPIO: lvl = gpio;
      PIN_OSC:  lvl = 1'b0;
      PIN_HALF: lvl = cnt[0];
      default:  lvl = cnt[DIV_W-1];
    endcase
    return lvl;
  endfunction

  // A handoff is safe when both sources stay low for the coming low phase.
  function automatic logic handoff_ok(pin_mode_e cur, pin_mode_e nxt,
                                      logic [DIV_W-1:0] cnt, logic gpio);
    return (cur != nxt) && !low_phase_level(cur, cnt, gpio) && !low_phase_level(nxt, cnt, gpio);
  endfunction
endpackage

// File: rtl/clkout_ctrl_reg.sv
`timescale 1ns/1ps
module clkout_ctrl_reg
  import clkout_pkg::*;
#(
  parameter int DATA_W = CTRL_W
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output pin_mode_e         sel_q
);
  logic [SEL_W-1:0] sel_field;
  logic             unused_upper;

  assign sel_field    = wr_data[SEL_LSB +: SEL_W];
  assign unused_upper = ^wr_data;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)     sel_q <= PIN_GPIO;
    else if (wr_en) sel_q <= pin_mode_e'(sel_field);
  end

  AST_SEL_LOAD: assert property (@(posedge clk_osc) disable iff (!rst_n)
    wr_en |=> (sel_q == pin_mode_e'($past(wr_data[SEL_LSB +: SEL_W])))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q)); // R2
endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider
  import clkout_pkg::*;
#(
  parameter int CW = DIV_W
) (
  input  logic          clk_osc,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_q
);
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  AST_HALF_TOGGLE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $past(rst_n) |-> (cnt_q[0] != $past(cnt_q[0]))); // R5
  AST_QUARTER_TOGGLE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $past(rst_n) |-> ((cnt_q[1] != $past(cnt_q[1])) == $past(cnt_q[0]))); // R6
endmodule

// File: rtl/clkout_switch.sv
`timescale 1ns/1ps
module clkout_switch
  import clkout_pkg::*;
(
  input  logic             clk_osc,
  input  logic             rst_n,
  input  pin_mode_e        req_mode,
  input  logic [DIV_W-1:0] cnt,
  input  logic             gpio,
  output pin_mode_e        act_mode,
  output logic             pad
);
  logic take_new;

  assign take_new = handoff_ok(act_mode, req_mode, cnt, gpio);

  // Falling-edge handoff: the low phase that follows is quiet on both sources.
  always_ff @(negedge clk_osc or negedge rst_n) begin
    if (!rst_n)        act_mode <= PIN_GPIO;
    else if (take_new) act_mode <= req_mode;
  end

  always_comb begin
    unique case (act_mode)
      PIN_GPIO: pad = gpio;
      PIN_OSC:  pad = clk_osc;
      PIN_HALF: pad = cnt[0];
      default:  pad = cnt[DIV_W-1];
    endcase
  end

  AST_MODE_TARGET: assert property (@(negedge clk_osc) disable iff (!rst_n)
    (act_mode != $past(act_mode)) |-> (act_mode == $past(req_mode))); // R7
endmodule

// File: rtl/clkout_pin_mux.sv
`timescale 1ns/1ps
module clkout_pin_mux
  import clkout_pkg::*;
(
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              gpio_dout,
  output logic              pad_out
);
  pin_mode_e        sel_mode;
  pin_mode_e        live_mode;
  logic [DIV_W-1:0] div_cnt;

  clkout_ctrl_reg #(.DATA_W(CTRL_W)) u_reg (
    .clk_osc (clk_osc),
    .rst_n   (rst_n),
    .wr_en   (ctrl_wr),
    .wr_data (ctrl_wdata),
    .sel_q   (sel_mode)
  );

  clkout_divider #(.CW(DIV_W)) u_div (
    .clk_osc (clk_osc),
    .rst_n   (rst_n),
    .cnt_q   (div_cnt)
  );

  clkout_switch u_sw (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .req_mode (sel_mode),
    .cnt      (div_cnt),
    .gpio     (gpio_dout),
    .act_mode (live_mode),
    .pad      (pad_out)
  );

  AST_RESET_GPIO: assert property (@(posedge clk_osc)
    !rst_n |-> (live_mode == PIN_GPIO)); // R1
endmodule

// File: tb/clkout_pin_mux_tb_top.sv
`timescale 1ns/1ps
module clkout_pin_mux_tb_top;
  localparam int  CLK_PER = 10;
  localparam real HALF_T  = CLK_PER / 2.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       gpio = 1'b0;
  logic       pad;

  int  n_chk = 0;
  int  n_fail = 0;
  int  runts = 0;
  int  pad_edges = 0;
  bit  done = 1'b0;
  real last_edge = 0.0;

  always #(CLK_PER/2) clk = ~clk;

  clkout_pin_mux dut_i (
    .clk_osc (clk), .rst_n (rst_n), .ctrl_wr (wr),
    .ctrl_wdata (wdata), .gpio_dout (gpio), .pad_out (pad)
  );

  // Pulse-width monitor for R8
  always @(pad) begin
    if (rst_n) begin
      pad_edges++;
      if (($realtime - last_edge) < HALF_T) runts++;
    end
    last_edge = $realtime;
  end

  function automatic int cycles_for(logic [7:0] w);
    int s = w % 4;
    return (s == 0) ? 0 : (1 << (s - 1));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(logic [7:0] v);
    wdata = v; wr = 1'b1;
    @(posedge clk); #2;
    wr = 1'b0;
  endtask

  task automatic measure(int cyc, string req);
    real t1, t2, t3;
    @(posedge pad); t1 = $realtime;
    @(negedge pad); t2 = $realtime;
    @(posedge pad); t3 = $realtime;
    chk((t3 - t1) == real'(cyc * CLK_PER), req, int'(t3 - t1), cyc * CLK_PER);
    chk((t2 - t1) == real'(cyc * CLK_PER) / 2.0, req, int'(t2 - t1), cyc * CLK_PER / 2);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: GPIO passthrough while held in reset
    repeat (2) @(posedge clk);
    #2 gpio = 1'b1; #1;
    chk(pad == 1'b1, "R1", pad, 1);
    gpio = 1'b0; #1;
    chk(pad == 1'b0, "R1", pad, 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R1 and R3: GPIO mode after reset, random data levels
    for (int i = 0; i < 8; i++) begin
      gpio = 1'($urandom);
      @(negedge clk); #1;
      chk(pad == gpio, "R3", pad, gpio);
      @(posedge clk); #2;
    end
    gpio = 1'b0;
    @(posedge clk); #2;

    // R7: handoff timing from GPIO low to undivided clock
    wdata = 8'h01; wr = 1'b1;
    @(posedge clk); #2 wr = 1'b0;
    chk(pad == 1'b0, "R7", pad, 0);
    @(posedge clk); #2;
    chk(pad == 1'b1, "R7", pad, 1);
    #5;
    chk(pad == 1'b0, "R7", pad, 0);

    // R4, R5, R6: each ratio measured
    measure(cycles_for(8'h01), "R4");
    write_ctrl(8'h02); repeat (6) @(posedge clk); #2;
    measure(cycles_for(8'h02), "R5");
    write_ctrl(8'h03); repeat (8) @(posedge clk); #2;
    measure(cycles_for(8'h03), "R6");

    // R2: upper bits carry junk and must not change the decode
    write_ctrl(8'hFE); repeat (8) @(posedge clk); #2;
    measure(cycles_for(8'hFE), "R2");
    write_ctrl(8'hFD); repeat (8) @(posedge clk); #2;
    measure(cycles_for(8'hFD), "R2");
    write_ctrl(8'hFC); repeat (4) @(posedge clk); #2;
    gpio = 1'b1; #1;
    chk(pad == 1'b1, "R2", pad, 1);
    gpio = 1'b0; #1;
    chk(pad == 1'b0, "R2", pad, 0);

    // R9: GPIO held high blocks the handoff
    gpio = 1'b1;
    @(posedge clk); #2;
    write_ctrl(8'h01);
    begin
      int highs = 0;
      for (int i = 0; i < 12; i++) begin
        #(CLK_PER/2);
        if (pad == 1'b1) highs++;
      end
      chk(highs == 12, "R9", highs, 12);
    end
    @(posedge clk); #2 gpio = 1'b0;
    repeat (3) @(posedge clk); #2;
    measure(1, "R9");

    // R8: random select rewrites mixed with random GPIO levels
    runts = 0; pad_edges = 0;
    for (int i = 0; i < 80; i++) begin
      int hold = 1 + ($urandom % 10);
      write_ctrl(8'($urandom));
      for (int k = 0; k < hold; k++) begin
        gpio = 1'($urandom);
        @(posedge clk); #2;
      end
    end
    chk(runts == 0, "R8", runts, 0);
    chk(pad_edges > 100, "R8", pad_edges, 101);

    gpio = 1'b0;
    write_ctrl(8'h03); repeat (10) @(posedge clk); #2;
    measure(4, "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule